// File: doc/BRIEF.md
# Priority-Coded Channel Shutdown Controller

This block sheds load from a set of power channels on command. Each channel holds a 3-bit shutdown rank. A 3-bit code arrives as a short train of pulses on one serial input. When the last bit of a code has been decoded, the block compares the code with every channel's rank. It turns off each channel that is powered and whose rank is not below the code. A small rank means the channel is important. Rank 0 falls only to code 0, and rank 7 falls to any code.

For every channel it turns off, the block emits a one-cycle turn-off strobe and, in the same cycle, a one-cycle status-clear strobe. The status-clear strobe lets the surrounding logic wipe that channel's status and measurements. Unlike a full channel reset, the shutdown leaves the channel's fault cool-down counter running. The block keeps no record of earlier codes: each code is judged by itself.

The ranks and a global enable sit behind a byte-wide register port. The channel power state is a plain input. The cool-down counters are a simple stand-in that a fault input loads and a channel-reset input clears.

Top module: `prio_shed_ctrl`

## Requirements
- R1: After reset, every rank field reads 0, the enable bit reads 0, no strobe is asserted and every cool-down counter is 0.
- R2: Register address 0 holds channel 0's rank in bits 2:0 and channel 1's rank in bits 6:4. Address 1 holds channels 2 and 3 in the same bit positions. Address 2 holds the enable in bit 0. Every other bit reads 0, and reads are combinational.
- R3: A serial code is three high pulses sent most significant bit first. After a 2-flop synchronizer, a pulse that stays high for more than LONG_THR clock cycles is a 1, and any shorter pulse is a 0.
- R4: When a code completes, each channel that is powered and whose rank is greater than or equal to the code is turned off. Channels that hold equal ranks fall together.
- R5: While the enable bit is 0, a received code produces no strobe.
- R6: A channel whose power input is low receives no strobe, and its cool-down counter is unchanged.
- R7: The turn-off strobe and the status-clear strobe for a channel are high together, for exactly one cycle, once per qualifying code.
- R8: Each code is evaluated with no memory of previous codes. Sending the same code twice strobes the same channels twice.
- R9: A code is acted on as soon as its third bit is decoded. When that bit is a 1, the strobe appears while the final pulse is still high.
- R10: If the line stays low for GAP_TO cycles with only one or two bits received, those bits are discarded.
- R11: A fault input loads that channel's cool-down counter with COOL_LEN. The counter then counts down by one per cycle to 0, and a shutdown does not disturb it. A channel-reset input clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shed_in | input | 1 | Asynchronous serial shutdown-code line, active high pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ch_on | input | NUM_CH | Channel currently powered |
| fault_start | input | NUM_CH | Starts a fault cool-down on the channel |
| chan_rst | input | NUM_CH | Channel reset, which clears the cool-down |
| off_stb | output | NUM_CH | One-cycle turn-off strobe per channel |
| clr_stb | output | NUM_CH | One-cycle status-clear strobe per channel |
| cool_cnt | output | NUM_CH*COOL_W | Packed cool-down counters, channel 0 in the low bits |

## Verification
A wrong bit count or a stale shift value in the receiver shows at the strobe outputs within the next complete code. Either the wrong channels are strobed, or no channel is strobed when the code is sent a second time. A rank field decoded from the wrong bit positions shows on the very next register read, and again in the set of channels that a code turns off. If the shutdown were allowed to reach the cool-down counter, the counter would jump away from its one-per-cycle descent in the cycle after the strobe. A missing discard of a partial code would make the next full code turn off a channel whose rank should have spared it.

// File: rtl/prio_shed_pkg.sv
package prio_shed_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/shed_serial_rx.sv
module shed_serial_rx
  import prio_shed_pkg::*;
#(
  parameter int LONG_THR = 8,
  parameter int GAP_TO   = 40
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_in,
  output logic  code_vld,
  output prio_t code
);
  localparam int LIM = (LONG_THR > GAP_TO) ? LONG_THR : GAP_TO;
  localparam int CW  = $clog2(LIM + 1);

  logic          sy1_q, sy2_q, prev_q;
  logic [CW-1:0] hi_q, hi_d, gap_q, gap_d;
  logic          taken_q, taken_d;
  logic [1:0]    nbit_q, nbit_d;
  logic [1:0]    shf_q, shf_d;
  logic          vld_q, vld_d;
  prio_t         code_q, code_d;
  logic          take, tbit;

  always_comb begin
    hi_d    = hi_q;
    gap_d   = gap_q;
    taken_d = taken_q;
    nbit_d  = nbit_q;
    shf_d   = shf_q;
    vld_d   = 1'b0;
    code_d  = code_q;
    take    = 1'b0;
    tbit    = 1'b0;
    if (sy2_q) begin
      gap_d = '0;
      if (!taken_q) begin
        if (hi_q == CW'(LONG_THR)) begin
          take    = 1'b1;
          tbit    = 1'b1;
          taken_d = 1'b1;
        end else begin
          hi_d = hi_q + 1'b1;
        end
      end
    end else begin
      hi_d    = '0;
      taken_d = 1'b0;
      if (prev_q && !taken_q) begin
        take = 1'b1;
      end else if (nbit_q != 2'd0) begin
        if (gap_q == CW'(GAP_TO - 1)) begin
          nbit_d = 2'd0;
          gap_d  = '0;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
    end
    if (take) begin
      if (nbit_q == 2'd2) begin
        vld_d  = 1'b1;
        code_d = {shf_q, tbit};
        nbit_d = 2'd0;
      end else begin
        shf_d  = {shf_q[0], tbit};
        nbit_d = nbit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q   <= 1'b0;
      sy2_q   <= 1'b0;
      prev_q  <= 1'b0;
      hi_q    <= '0;
      gap_q   <= '0;
      taken_q <= 1'b0;
      nbit_q  <= 2'd0;
      shf_q   <= 2'd0;
      vld_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      sy1_q   <= line_in;
      sy2_q   <= sy1_q;
      prev_q  <= sy2_q;
      hi_q    <= hi_d;
      gap_q   <= gap_d;
      taken_q <= taken_d;
      nbit_q  <= nbit_d;
      shf_q   <= shf_d;
      vld_q   <= vld_d;
      code_q  <= code_d;
    end
  end

  assign code_vld = vld_q;
  assign code     = code_q;
endmodule

// File: rtl/shed_prio_regs.sv
module shed_prio_regs
  import prio_shed_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output prio_t             prio [NUM_CH],
  output logic              mben
);
  localparam int MODE_ADDR = (NUM_CH + 1) / 2;

  prio_t prio_q [NUM_CH];
  prio_t prio_d [NUM_CH];
  logic  mben_q, mben_d;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_rank
    always_comb begin
      prio_d[g] = prio_q[g];
      if (wr && addr == ADDR_W'(g / 2)) prio_d[g] = wdata[(g % 2) * 4 +: PRIO_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q[g] <= '0;
      else        prio_q[g] <= prio_d[g];
    end
    assign prio[g] = prio_q[g];
  end

  always_comb begin
    mben_d = mben_q;
    if (wr && addr == ADDR_W'(MODE_ADDR)) mben_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mben_q <= 1'b0;
    else        mben_q <= mben_d;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(MODE_ADDR)) rdata[0] = mben_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i / 2)) rdata[(i % 2) * 4 +: PRIO_W] = prio_q[i];
    end
  end

  assign mben = mben_q;
endmodule

// File: rtl/shed_chan_eval.sv
module shed_chan_eval
  import prio_shed_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int COOL_W   = 8,
  parameter int COOL_LEN = 100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          code_vld,
  input  prio_t                         code,
  input  logic                          mben,
  input  prio_t                         prio [NUM_CH],
  input  logic [NUM_CH-1:0]             ch_on,
  input  logic [NUM_CH-1:0]             fault_start,
  input  logic [NUM_CH-1:0]             chan_rst,
  output logic [NUM_CH-1:0]             off_stb,
  output logic [NUM_CH-1:0]             clr_stb,
  output logic [NUM_CH-1:0][COOL_W-1:0] cool
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic              hit;
    logic              off_q, clr_q;
    logic [COOL_W-1:0] cool_q, cool_d;

    assign hit = code_vld & mben & ch_on[g] & (code <= prio[g]);

    always_comb begin
      cool_d = cool_q;
      if (chan_rst[g])          cool_d = '0;
      else if (fault_start[g])  cool_d = COOL_W'(COOL_LEN);
      else if (cool_q != '0)    cool_d = cool_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q  <= 1'b0;
        clr_q  <= 1'b0;
        cool_q <= '0;
      end else begin
        off_q  <= hit;
        clr_q  <= hit;
        cool_q <= cool_d;
      end
    end

    assign off_stb[g] = off_q;
    assign clr_stb[g] = clr_q;
    assign cool[g]    = cool_q;
  end
endmodule

// File: rtl/prio_shed_ctrl.sv
module prio_shed_ctrl
  import prio_shed_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 2,
  parameter int LONG_THR = 8,
  parameter int GAP_TO   = 40,
  parameter int COOL_W   = 8,
  parameter int COOL_LEN = 100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shed_in,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic [NUM_CH-1:0]        ch_on,
  input  logic [NUM_CH-1:0]        fault_start,
  input  logic [NUM_CH-1:0]        chan_rst,
  output logic [NUM_CH-1:0]        off_stb,
  output logic [NUM_CH-1:0]        clr_stb,
  output logic [NUM_CH*COOL_W-1:0] cool_cnt
);
  logic rs1_q, rst_q_n;
  logic code_vld, mben;
  prio_t code;
  prio_t prio [NUM_CH];
  logic [NUM_CH-1:0][COOL_W-1:0] cool;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_q_n <= rs1_q;
    end
  end

  shed_serial_rx #(.LONG_THR(LONG_THR), .GAP_TO(GAP_TO)) u_rx (
    .clk(clk), .rst_n(rst_q_n), .line_in(shed_in),
    .code_vld(code_vld), .code(code)
  );

  shed_prio_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .prio(prio), .mben(mben)
  );

  shed_chan_eval #(.NUM_CH(NUM_CH), .COOL_W(COOL_W), .COOL_LEN(COOL_LEN)) u_eval (
    .clk(clk), .rst_n(rst_q_n), .code_vld(code_vld), .code(code),
    .mben(mben), .prio(prio), .ch_on(ch_on), .fault_start(fault_start),
    .chan_rst(chan_rst), .off_stb(off_stb), .clr_stb(clr_stb), .cool(cool)
  );

  assign cool_cnt = cool;
endmodule

// File: rtl/prio_shed_chk.sv
module prio_shed_chk #(
  parameter int NUM_CH = 4,
  parameter int COOL_W = 8
) (
  input logic                     clk,
  input logic                     rst_q_n,
  input logic                     mben,
  input logic [NUM_CH-1:0]        ch_on,
  input logic [NUM_CH-1:0]        fault_start,
  input logic [NUM_CH-1:0]        chan_rst,
  input logic [NUM_CH-1:0]        off_stb,
  input logic [NUM_CH*COOL_W-1:0] cool_cnt
);
  assert_gate_by_enable_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (off_stb != '0) |-> $past(mben));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    assert_off_needs_power_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
      off_stb[g] |-> $past(ch_on[g]));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
      off_stb[g] |=> !off_stb[g]);

    assert_cool_descends_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
      (cool_cnt[g*COOL_W +: COOL_W] != '0 && !fault_start[g] && !chan_rst[g])
      |=> cool_cnt[g*COOL_W +: COOL_W] == $past(cool_cnt[g*COOL_W +: COOL_W]) - 1'b1);

    assert_cool_cleared_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
      chan_rst[g] |=> cool_cnt[g*COOL_W +: COOL_W] == '0);
  end
endmodule

bind prio_shed_ctrl prio_shed_chk #(.NUM_CH(NUM_CH), .COOL_W(COOL_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .mben(mben), .ch_on(ch_on),
  .fault_start(fault_start), .chan_rst(chan_rst), .off_stb(off_stb),
  .cool_cnt(cool_cnt)
);

// File: tb/sim_prio_shed_ctrl.sv
`timescale 1ns/1ps
module sim_prio_shed_ctrl;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int CLEN = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shed_in = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [NCH-1:0] ch_on = '1;
  logic [NCH-1:0] fault_start = '0;
  logic [NCH-1:0] chan_rst = '0;
  logic [NCH-1:0] off_stb, clr_stb;
  logic [NCH*CW-1:0] cool_cnt;

  int errs = 0, checks = 0, mism = 0, cyc = 0;
  int tot [NCH];
  logic line_at_stb = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_shed_ctrl #(.COOL_LEN(CLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .shed_in(shed_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_on(ch_on), .fault_start(fault_start), .chan_rst(chan_rst),
    .off_stb(off_stb), .clr_stb(clr_stb), .cool_cnt(cool_cnt)
  );

  initial for (int i = 0; i < NCH; i++) tot[i] = 0;

  always @(posedge clk) begin
    #2;
    cyc++;
    for (int i = 0; i < NCH; i++) if (off_stb[i]) tot[i]++;
    if (off_stb != clr_stb) mism++;
    if (off_stb != '0) line_at_stb = shed_in;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [2:0] v, input int n, input int idle);
    for (int k = n - 1; k >= 0; k--) begin
      shed_in = 1'b1;
      repeat (v[k] ? 16 : 3) @(negedge clk);
      shed_in = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (idle) @(negedge clk);
  endtask

  function automatic logic [CW-1:0] cool_of(input int i);
    return cool_cnt[i*CW +: CW];
  endfunction

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
      end
    join_none
  end

  initial begin
    logic [7:0] rd;
    int snap [NCH];
    int q [NCH];
    int a, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int ad = 0; ad < 3; ad++) begin
      rd_reg(2'(ad), rd);
      chk(rd == 8'd0, "R1 reg reset", rd, 0);
    end
    chk(off_stb == '0 && clr_stb == '0, "R1 strobes idle", off_stb, 0);
    chk(cool_cnt == '0, "R1 cool zero", int'(cool_cnt[CW-1:0]), 0);

    // R2 register layout and unused bits
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, rd); chk(rd == 8'h77, "R2 addr0 layout", rd, 8'h77);
    wr_reg(2'd1, 8'h35); rd_reg(2'd1, rd); chk(rd == 8'h35, "R2 addr1 layout", rd, 8'h35);
    wr_reg(2'd2, 8'hFF); rd_reg(2'd2, rd); chk(rd == 8'h01, "R2 enable bit", rd, 1);

    // R5 disabled: rank 7 everywhere, code 0 sent
    wr_reg(2'd0, 8'h77); wr_reg(2'd1, 8'h77); wr_reg(2'd2, 8'h00);
    for (int i = 0; i < NCH; i++) snap[i] = tot[i];
    send(3'd0, 3, 60);
    for (int i = 0; i < NCH; i++)
      chk(tot[i] == snap[i], "R5 disabled no strobe", tot[i] - snap[i], 0);
    wr_reg(2'd2, 8'h01);

    // R3 R4 R8 R9 sweep of codes against rotating ranks
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < NCH; i++) q[i] = (p + 3 * i) % 8;
      wr_reg(2'd0, 8'((q[1] << 4) | q[0]));
      wr_reg(2'd1, 8'((q[3] << 4) | q[2]));
      for (int c = 0; c < 8; c++) begin
        bit any;
        any = 1'b0;
        for (int i = 0; i < NCH; i++) snap[i] = tot[i];
        send(3'(c), 3, 60);
        for (int i = 0; i < NCH; i++) begin
          int e;
          e = (c <= q[i]) ? 1 : 0;
          if (e == 1) any = 1'b1;
          chk(tot[i] - snap[i] == e, "R4 R3 R8 compare", tot[i] - snap[i], e);
        end
        if (any && c[0]) chk(line_at_stb == 1'b1, "R9 early act", line_at_stb, 1);
      end
    end
    chk(mism == 0, "R7 paired strobes", mism, 0);

    // R8 same code twice strobes twice
    wr_reg(2'd0, 8'h22); wr_reg(2'd1, 8'h22);
    for (int i = 0; i < NCH; i++) snap[i] = tot[i];
    send(3'd2, 3, 60); send(3'd2, 3, 60);
    chk(tot[0] - snap[0] == 2, "R8 repeat code", tot[0] - snap[0], 2);

    // R10 partial code discarded, then code 7 against ranks 6,7,7,7
    wr_reg(2'd0, 8'h76); wr_reg(2'd1, 8'h77);
    for (int i = 0; i < NCH; i++) snap[i] = tot[i];
    send(3'd0, 2, 60);
    send(3'd7, 3, 60);
    chk(tot[0] - snap[0] == 0, "R10 partial discarded ch0", tot[0] - snap[0], 0);
    chk(tot[1] - snap[1] == 1, "R10 full code ch1", tot[1] - snap[1], 1);

    // R6 powered-off channels get no strobe
    ch_on = 4'b0101;
    for (int i = 0; i < NCH; i++) snap[i] = tot[i];
    send(3'd0, 3, 60);
    for (int i = 0; i < NCH; i++)
      chk(tot[i] - snap[i] == (i % 2 == 0 ? 1 : 0), "R6 off channel skipped",
          tot[i] - snap[i], (i % 2 == 0 ? 1 : 0));
    ch_on = '1;

    // R11 cool-down survives shutdown, channel reset clears it
    @(negedge clk); fault_start = 4'b0010;
    @(negedge clk); fault_start = '0;
    a = cool_of(1); c1 = cyc;
    chk(a == CLEN, "R11 load", a, CLEN);
    for (int i = 0; i < NCH; i++) snap[i] = tot[i];
    send(3'd0, 3, 20);
    chk(tot[1] - snap[1] == 1, "R11 shutdown occurred", tot[1] - snap[1], 1);
    chk(int'(cool_of(1)) == a - (cyc - c1), "R11 cool kept", cool_of(1), a - (cyc - c1));
    chk(cool_of(3) == '0, "R11 idle channel", cool_of(3), 0);
    @(negedge clk); chan_rst = 4'b0010;
    @(negedge clk); chan_rst = '0;
    chk(cool_of(1) == '0, "R11 reset clears", cool_of(1), 0);

    finish_run();
  end
endmodule